// File: doc/BRIEF.md
# Audio Controller Register and Interrupt Unit

This block is the host-visible register file of a three-channel audio controller with two playback channels and one capture channel. A host reaches it through a small synchronous bus over a 256-byte I/O window, using byte, 16-bit or 32-bit accesses. It holds the control word, the status word, a 4-bit page register, a codec word and the serial-control word. It merges partial writes into the existing register contents and remaps a paged sub-window of the window through the page register.

The channel engines sit outside. The block tells each engine whether it may run, as the channel's enable bit in control qualified by its pause bit in serial control. Each engine raises a one-cycle pulse when it wants to flag an event. The block latches that pulse as a pending bit only while the channel's interrupt enable is set. It drives one level interrupt from the pending bits and mirrors that interrupt in the top bit of the status word. Turning an interrupt enable off clears the matching pending bit.

Top module: `audio_reg_unit`

## Requirements
- R1: After reset, a 32-bit read returns 0x00000001 for control (offset 0x00), 0x00000060 for status (0x04), 0 for page (0x0C), 0 for codec (0x10) and 0 for serial control (0x20), and `irq` is low.
- R2: Only the low 8 address bits select a register. When those bits lie in 0x30–0x3F, the page value is placed in effective address bits 11:8. No register of this block answers there, so such reads, including the unused frame slots at effective 0xD38 and 0xD3C, return 0xFFFFFFFF.
- R3: A byte write (size code 0) to offsets 0x00–0x03 or 0x20–0x23 replaces only lane (offset & 3) of control or serial control, and byte data is taken from `bus_wdata[7:0]`.
- R4: A 16-bit write (size code 1) to control at 0x00 or 0x02 replaces only the low or high half. A 16-bit write at 0x10 loads the codec word with `bus_wdata[15:0]` zero-extended. A 32-bit write at 0x10 is ignored.
- R5: A byte or 32-bit (size code 2) write to the page register at 0x0C keeps only bits 3:0 of the data.
- R6: Status bit 2 is the playback-1 pending bit, bit 1 the playback-2 pending bit and bit 0 the capture pending bit. Bits 6:5 read as 1. Bit 31 is set exactly when any of bits 2:0 is set, and `irq` equals bit 31.
- R7: `set_pend[0]`, `set_pend[1]` and `set_pend[2]` (playback 1, playback 2, capture) set their pending bit on the next edge only if serial-control bit 8, 9 or 10 respectively is 1 at that edge.
- R8: A write that changes serial-control bit 8, 9 or 10 from 1 to 0 clears the matching pending bit. A clear of this kind wins over a same-cycle set pulse.
- R9: `chan_run[0]` is control bit 6 AND NOT serial-control bit 11. `chan_run[1]` is control bit 5 AND NOT serial-control bit 12. `chan_run[2]` is control bit 4, and no serial-control bit affects it.
- R10: A byte read at 0x1B returns 5. A byte read at 0x0C returns the page value. A byte read at lane L of control (0x00–0x03) or status (0x04–0x07) returns the register shifted right by 8×L.
- R11: Read data appears on `bus_rdata` on the edge after `bus_rd`. Any 16-bit read, any read with size code 3 and any unmapped read returns 0xFFFFFFFF. Writes with size code 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (16) | Byte offset into the I/O window |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 none |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| set_pend | input | 3 | Per-channel set-pending pulses from the engines |
| chan_run | output | 3 | Per-channel run permission |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can fall in the same cycle: an engine's set-pending pulse, and a host write to serial control that drops that channel's interrupt enable. The bench provokes this by driving a byte write to lane 1 of serial control in the very cycle that `set_pend` pulses for the channel being disabled. It then judges the result from `irq` and from a later status read, which must show the bit clear. A behavioural model in the bench predicts the pending bits, the interrupt, the run outputs and every read word on every clock.

// File: rtl/audreg_pkg.sv
// Package: shared access-size type and register constants for the
// audio register unit. Assumes a 32-bit register width.
package audreg_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } acc_size_e;

    localparam logic [31:0] CTL_RESET   = 32'h0000_0001;
    localparam logic [31:0] ALL_ONES    = 32'hFFFF_FFFF;
    localparam logic [7:0]  LEGACY_BYTE = 8'h05;
endpackage

// File: rtl/audreg_addr_map.sv
// Address map: folds the bus offset into the 256-byte window, applies the
// page register to the paged sub-window and decodes register selects.
// Assumes register offsets below 0x30 are unpaged.
module audreg_addr_map #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 4,
    localparam int EFF_W = 8 + PAGE_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] page,
    output logic              sel_ctl,
    output logic              sel_stat,
    output logic              sel_sctl,
    output logic              sel_page,
    output logic              sel_codec,
    output logic              sel_legacy,
    output logic [1:0]        lane
);
    logic [EFF_W-1:0] eff;
    logic             unused_hi;

    assign unused_hi = ^addr[ADDR_W-1:8];

    // Build the effective address, pasting in the page inside 0x30-0x3F.
    always_comb begin
        eff = {{PAGE_W{1'b0}}, addr[7:0]};
        if (addr[7:4] == 4'h3) begin
            eff[EFF_W-1:8] = page;
        end
    end

    // Decode register selects from the effective address.
    always_comb begin
        sel_ctl    = (eff[EFF_W-1:2] == (EFF_W-2)'(0));
        sel_stat   = (eff[EFF_W-1:2] == (EFF_W-2)'(1));
        sel_sctl   = (eff[EFF_W-1:2] == (EFF_W-2)'(8));
        sel_page   = (eff == EFF_W'(12'h00C));
        sel_codec  = (eff == EFF_W'(12'h010));
        sel_legacy = (eff == EFF_W'(12'h01B));
        lane       = eff[1:0];
    end
endmodule

// File: rtl/audreg_lane_merge.sv
// Lane merge: replaces the byte lanes covered by an access of the given
// size and lane in an old register value. Assumes legal alignment is
// checked by the caller.
module audreg_lane_merge
    import audreg_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NLANES = DATA_W / 8,
    localparam int LANE_W = $clog2(NLANES)
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] wr_val,
    input  acc_size_e         size,
    input  logic [LANE_W-1:0] lane,
    output logic [DATA_W-1:0] merged
);
    logic [DATA_W-1:0] shifted;

    // Move right-aligned write data up to the addressed lane.
    always_comb shifted = wr_val << {lane, 3'b000};

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam logic [LANE_W-1:0] GL = LANE_W'(g);
        logic hit;
        // Decide whether this lane is covered, then pick new or old byte.
        always_comb begin
            hit = (size == SZ_WORD)
               || (size == SZ_BYTE && lane == GL)
               || (size == SZ_HALF && lane[LANE_W-1:1] == GL[LANE_W-1:1]);
            merged[g*8 +: 8] = hit ? shifted[g*8 +: 8] : old_val[g*8 +: 8];
        end
    end
endmodule

// File: rtl/audreg_pend.sv
// Pending flags: one sticky bit per channel, set by an engine pulse while
// the channel's interrupt enable is on, cleared by an enable drop (which
// wins). Drives the OR of all bits as the interrupt level.
module audreg_pend #(
    parameter int NCHAN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCHAN-1:0] set_pulse,
    input  logic [NCHAN-1:0] enable,
    input  logic [NCHAN-1:0] clear,
    output logic [NCHAN-1:0] pend,
    output logic             any
);
    for (genvar c = 0; c < NCHAN; c++) begin : g_ch
        // Update one channel's pending bit; clear has priority over set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[c] <= 1'b0;
            end else if (clear[c]) begin
                pend[c] <= 1'b0;
            end else if (set_pulse[c] && enable[c]) begin
                pend[c] <= 1'b1;
            end
        end
    end

    // Interrupt level is the OR of the pending bits.
    always_comb any = |pend;
endmodule

// File: rtl/audio_reg_unit.sv
// Audio register unit: host register file for two playback channels and
// one capture channel. Merges partial writes, serves reads one cycle
// later, exports run permissions and a level interrupt.
// Assumes a single host and one access per cycle.
module audio_reg_unit
    import audreg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 4,
    parameter int NCHAN  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCHAN-1:0]  set_pend,
    output logic [NCHAN-1:0]  chan_run,
    output logic              irq
);
    localparam int IEN_LSB = 8;

    acc_size_e         size;
    logic              sel_ctl, sel_stat, sel_sctl, sel_page, sel_codec, sel_legacy;
    logic [1:0]        lane;
    logic [31:0]       ctl_q, sctl_q, codec_q, ctl_new, sctl_new, stat_w, rd_w;
    logic [PAGE_W-1:0] page_q;
    logic              ctl_we, sctl_we, page_we, codec_we;
    logic [NCHAN-1:0]  ien_old, ien_new, ien_drop, pend;

    assign size = acc_size_e'(bus_size);

    audreg_addr_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_map (
        .addr(bus_addr), .page(page_q),
        .sel_ctl(sel_ctl), .sel_stat(sel_stat), .sel_sctl(sel_sctl),
        .sel_page(sel_page), .sel_codec(sel_codec), .sel_legacy(sel_legacy),
        .lane(lane)
    );

    audreg_lane_merge #(.DATA_W(32)) u_ctl_merge (
        .old_val(ctl_q), .wr_val(bus_wdata), .size(size), .lane(lane),
        .merged(ctl_new)
    );

    audreg_lane_merge #(.DATA_W(32)) u_sctl_merge (
        .old_val(sctl_q), .wr_val(bus_wdata), .size(size), .lane(lane),
        .merged(sctl_new)
    );

    // Qualify write strobes by register and legal size/alignment.
    always_comb begin
        ctl_we   = bus_wr && sel_ctl && ((size == SZ_BYTE)
                 || (size == SZ_HALF && !lane[0]) || (size == SZ_WORD && lane == 2'd0));
        sctl_we  = bus_wr && sel_sctl && ((size == SZ_BYTE)
                 || (size == SZ_WORD && lane == 2'd0));
        page_we  = bus_wr && sel_page && (size == SZ_BYTE || size == SZ_WORD);
        codec_we = bus_wr && sel_codec && (size == SZ_HALF);
    end

    // Detect interrupt enables falling from 1 to 0 on a serial-control write.
    always_comb begin
        ien_old  = sctl_q[IEN_LSB +: NCHAN];
        ien_new  = sctl_new[IEN_LSB +: NCHAN];
        ien_drop = sctl_we ? (ien_old & ~ien_new) : '0;
    end

    audreg_pend #(.NCHAN(NCHAN)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_pulse(set_pend), .enable(ien_old),
        .clear(ien_drop), .pend(pend), .any(irq)
    );

    // Hold the host-written registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= CTL_RESET;
            sctl_q  <= '0;
            codec_q <= '0;
            page_q  <= '0;
        end else begin
            if (ctl_we)   ctl_q   <= ctl_new;
            if (sctl_we)  sctl_q  <= sctl_new;
            if (codec_we) codec_q <= {16'h0000, bus_wdata[15:0]};
            if (page_we)  page_q  <= bus_wdata[PAGE_W-1:0];
        end
    end

    // Assemble the status word: summary, fixed source field, pending bits.
    always_comb begin
        stat_w       = 32'h0000_0060;
        stat_w[31]   = irq;
        stat_w[2:0]  = {pend[0], pend[1], pend[2]};
    end

    // Select the read word for the current access.
    always_comb begin
        rd_w = ALL_ONES;
        unique case (size)
            SZ_BYTE: begin
                if (sel_legacy)    rd_w = {24'h0, LEGACY_BYTE};
                else if (sel_page) rd_w = 32'(page_q);
                else if (sel_ctl)  rd_w = ctl_q >> {lane, 3'b000};
                else if (sel_stat) rd_w = stat_w >> {lane, 3'b000};
            end
            SZ_WORD: begin
                if (lane == 2'd0) begin
                    if (sel_ctl)        rd_w = ctl_q;
                    else if (sel_stat)  rd_w = stat_w;
                    else if (sel_sctl)  rd_w = sctl_q;
                    else if (sel_page)  rd_w = 32'(page_q);
                    else if (sel_codec) rd_w = codec_q;
                end
            end
            default: rd_w = ALL_ONES;
        endcase
    end

    // Register read data one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_w;
    end

    // Export run permission: enable qualified by pause (capture has none).
    always_comb begin
        chan_run[0] = ctl_q[6] && !sctl_q[11];
        chan_run[1] = ctl_q[5] && !sctl_q[12];
        chan_run[2] = ctl_q[4];
    end
endmodule

// File: rtl/audreg_checker.sv
// Checker: temporal properties on the audio register unit's ports.
// Assumes synchronous active-low reset.
module audreg_checker #(
    parameter int NCHAN = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [1:0]       bus_size,
    input logic [31:0]      bus_rdata,
    input logic [NCHAN-1:0] set_pend,
    input logic [NCHAN-1:0] chan_run,
    input logic             irq
);
    // R1: interrupt is low right after reset is released.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !irq);

    // R7: the interrupt only rises after an engine pulse.
    p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|set_pend));

    // R8: the interrupt only falls after a host write.
    p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_wr));

    // R9: run permissions change only after a host write.
    p_run_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr) |-> $stable(chan_run));

    // R11: a read with size code 3 returns all ones.
    p_size_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_rd) && ($past(bus_size) == 2'd3)) |-> (bus_rdata == 32'hFFFF_FFFF));
endmodule

bind audio_reg_unit audreg_checker #(.NCHAN(NCHAN)) u_audreg_checker (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_size(bus_size), .bus_rdata(bus_rdata), .set_pend(set_pend),
    .chan_run(chan_run), .irq(irq)
);

// File: tb/audio_reg_unit_test.sv
// Bench: behavioural reference model compared on every clock.
module audio_reg_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  set_pend = '0;
    logic [2:0]  chan_run;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int unsigned m_ctl = 1, m_sctl = 0, m_codec = 0, m_page = 0;
    bit m_pend[3] = '{0, 0, 0};

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_reg_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .set_pend(set_pend), .chan_run(chan_run),
        .irq(irq)
    );

    function automatic int unsigned model_status();
        int unsigned s = 32'h60;
        if (m_pend[0]) s = s | 4;
        if (m_pend[1]) s = s | 2;
        if (m_pend[2]) s = s | 1;
        if (m_pend[0] || m_pend[1] || m_pend[2]) s = s | 32'h8000_0000;
        return s;
    endfunction

    function automatic int unsigned put_byte(int unsigned v, int lane, int unsigned d);
        int unsigned m = 32'hFF << (8 * lane);
        return (v & ~m) | ((d & 255) << (8 * lane));
    endfunction

    task automatic check(string tag, int unsigned got, int unsigned exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // One clock: drive, predict, then compare at the next falling edge.
    task automatic step(bit wr, bit rd, int sz, int unsigned a, int unsigned d,
                        bit [2:0] sp, string tag);
        int unsigned ea = a & 255;
        int lane;
        int unsigned exp_rd = 32'hFFFF_FFFF;
        int unsigned old_sctl = m_sctl;
        bit [2:0] clr = 0;
        bit exp_irq;
        bit [2:0] exp_run;
        if (ea >= 48 && ea <= 63) ea = ea | (m_page << 8);
        lane = int'(ea & 3);
        bus_wr = wr; bus_rd = rd; bus_size = sz[1:0]; bus_addr = a[15:0];
        bus_wdata = d; set_pend = sp;
        if (rd) begin
            if (sz == 0) begin
                if (ea == 27) exp_rd = 5;
                else if (ea == 12) exp_rd = m_page;
                else if (ea < 4) exp_rd = m_ctl >> (8 * lane);
                else if (ea >= 4 && ea < 8) exp_rd = model_status() >> (8 * lane);
            end else if (sz == 2) begin
                case (ea)
                    0: exp_rd = m_ctl;
                    4: exp_rd = model_status();
                    12: exp_rd = m_page;
                    16: exp_rd = m_codec;
                    32: exp_rd = m_sctl;
                    default: exp_rd = 32'hFFFF_FFFF;
                endcase
            end
        end
        if (wr) begin
            if (sz == 0) begin
                if (ea < 4) m_ctl = put_byte(m_ctl, lane, d);
                else if (ea == 12) m_page = d & 15;
                else if (ea >= 32 && ea < 36) m_sctl = put_byte(m_sctl, lane, d);
            end else if (sz == 1) begin
                if (ea == 0) m_ctl = (m_ctl & 32'hFFFF_0000) | (d & 32'hFFFF);
                else if (ea == 2) m_ctl = (m_ctl & 32'h0000_FFFF) | ((d & 32'hFFFF) << 16);
                else if (ea == 16) m_codec = d & 32'hFFFF;
            end else if (sz == 2) begin
                if (ea == 0) m_ctl = d;
                else if (ea == 12) m_page = d & 15;
                else if (ea == 32) m_sctl = d;
            end
        end
        for (int c = 0; c < 3; c++) begin
            bit was_on = old_sctl[8 + c];
            bit now_on = m_sctl[8 + c];
            clr[c] = was_on && !now_on;
            if (sp[c] && was_on) m_pend[c] = 1;
            if (clr[c]) m_pend[c] = 0;
        end
        exp_irq = m_pend[0] || m_pend[1] || m_pend[2];
        exp_run[0] = m_ctl[6] && !m_sctl[11];
        exp_run[1] = m_ctl[5] && !m_sctl[12];
        exp_run[2] = m_ctl[4];
        @(negedge clk);
        check({tag, " irq (R6)"}, 32'(irq), 32'(exp_irq));
        check({tag, " run (R9)"}, 32'(chan_run), 32'(exp_run));
        if (rd) check({tag, " rdata"}, bus_rdata, exp_rd);
        bus_wr = 0; bus_rd = 0; set_pend = 0;
    endtask

    task automatic rd32(int unsigned a, string tag);
        step(0, 1, 2, a, 0, 3'b000, tag);
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 0, 0, 3'b000, tag);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd32(32'h00, "R1 ctl");
        rd32(32'h04, "R1 status");
        rd32(32'h0C, "R1 page");
        rd32(32'h10, "R1 codec");
        rd32(32'h20, "R1 sctl");
        // R7 set ignored while enable off
        step(0, 0, 0, 0, 0, 3'b111, "R7 set while disabled");
        rd32(32'h04, "R7 status stays clear");
        // R7 enable and set playback 1
        step(1, 0, 2, 32'h20, 32'h0000_0700, 3'b000, "R7 enable all");
        step(0, 0, 0, 0, 0, 3'b001, "R7 set playback1");
        rd32(32'h04, "R6 status with playback1 pending");
        // R8 drop playback1 enable via byte lane 1
        step(1, 0, 0, 32'h21, 32'h06, 3'b000, "R8 drop enable");
        rd32(32'h04, "R8 status cleared");
        // R8 clear wins over same-cycle set
        step(1, 0, 0, 32'h21, 32'h07, 3'b000, "R8 re-enable");
        step(1, 0, 0, 32'h21, 32'h05, 3'b010, "R8 clear vs set same cycle");
        rd32(32'h04, "R8 clear wins");
        // capture pending, then word clear
        step(0, 0, 0, 0, 0, 3'b100, "R7 set capture");
        rd32(32'h04, "R6 status capture");
        step(0, 0, 0, 0, 0, 3'b001, "R7 set playback1 again");
        rd32(32'h04, "R6 two pending");
        step(1, 0, 2, 32'h20, 32'h0, 3'b000, "R8 word clear all");
        rd32(32'h04, "R8 none pending");
        // R3 / R4 control merging
        step(1, 0, 0, 32'h02, 32'hAB, 3'b000, "R3 ctl byte lane2");
        rd32(32'h00, "R3 ctl merged");
        step(1, 0, 1, 32'h02, 32'h1234, 3'b000, "R4 ctl high half");
        step(1, 0, 1, 32'h00, 32'h0070, 3'b000, "R4 ctl low half");
        rd32(32'h00, "R4 ctl halves");
        // R9 pause behaviour
        step(1, 0, 0, 32'h21, 32'h08, 3'b000, "R9 pause playback1");
        step(1, 0, 0, 32'h21, 32'h10, 3'b000, "R9 pause playback2");
        step(1, 0, 0, 32'h21, 32'h38, 3'b000, "R9 bit13 no capture pause");
        rd32(32'h20, "R3 sctl lane merge");
        step(1, 0, 0, 32'h00, 32'h00, 3'b000, "R9 disable all");
        // R5 page
        step(1, 0, 2, 32'h0C, 32'hFFFF_FFF7, 3'b000, "R5 page word");
        rd32(32'h0C, "R5 page low bits");
        step(1, 0, 0, 32'h0C, 32'h3A, 3'b000, "R5 page byte");
        step(0, 1, 0, 32'h0C, 0, 3'b000, "R10 page byte read");
        // R10 byte reads
        step(0, 1, 0, 32'h1B, 0, 3'b000, "R10 legacy byte");
        step(0, 1, 0, 32'h02, 0, 3'b000, "R10 ctl lane2");
        step(0, 1, 0, 32'h06, 0, 3'b000, "R10 status lane2");
        // R2 modulo and paged window
        rd32(32'h104, "R2 alias status");
        step(1, 0, 2, 32'h300, 32'h0000_0041, 3'b000, "R2 alias ctl write");
        rd32(32'h00, "R2 alias ctl read");
        step(1, 0, 0, 32'h0C, 32'h0D, 3'b000, "R2 page to D");
        rd32(32'h38, "R2 phantom addr");
        rd32(32'h3C, "R2 phantom count");
        step(1, 0, 0, 32'h0C, 32'h00, 3'b000, "R2 page to 0");
        rd32(32'h30, "R2 page0 frame slot");
        // R11 reads that return all ones, size 3 writes
        step(0, 1, 1, 32'h00, 0, 3'b000, "R11 half read");
        step(0, 1, 3, 32'h00, 0, 3'b000, "R11 size3 read");
        step(1, 0, 3, 32'h00, 32'hFFFF_FFFF, 3'b000, "R11 size3 write");
        rd32(32'h00, "R11 ctl unchanged");
        rd32(32'h08, "R11 unmapped");
        // R4 codec
        step(1, 0, 1, 32'h10, 32'hCAFE_BEEF, 3'b000, "R4 codec half");
        rd32(32'h10, "R4 codec read");
        step(1, 0, 2, 32'h10, 32'h1111_2222, 3'b000, "R4 codec word ignored");
        rd32(32'h10, "R4 codec kept");
        idle("end");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule